// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration space of one bus function. Software writes 1, 2 or 4 bytes at any offset, and only the bits enabled in each byte's write mask change. The masks are fixed at elaboration. The header bytes get a small fixed set of writable fields. The base address registers take masks computed from their size parameters. The device-specific area from 0x40 up is fully writable.

Reads return up to four bytes in little-endian order. When a wide access would run past the top of the space, the read is narrowed. A whole-image load port lets saved contents be restored in one cycle. Before it commits an image, the block checks every bit that is marked constant and not writable against the current contents. Any mismatch rejects the image and leaves the array untouched. A one-cycle remap pulse tells the address decoder when a write has touched the base address registers or the decode enables in the command byte.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, bytes 0x00-0x01 hold the vendor ID and 0x02-0x03 the device ID, both little-endian. Byte 0x08 holds the revision. Bytes 0x09-0x0B hold the class code, with the programming interface in 0x09 and the base class in 0x0B. Byte 0x0E holds the header type. Bit 0 of each base register's low byte (0x10 + 4n) equals that register's I/O flag. Every other byte is zero.
- R2: A write sets each addressed byte to (old AND NOT mask) OR (new AND mask). A byte whose mask is zero keeps its value, for example the ID bytes 0x00-0x03.
- R3: A write of length L at offset A updates bytes A..A+L-1. Data byte 0 (bits 7:0) goes to A, and each following data byte goes to the next higher offset. Bytes past offset 0xFF are dropped, and the walk never wraps to 0x00.
- R4: Byte 0x0C and byte 0x3C are fully writable. Byte 0x04 has only bits 0 (I/O enable), 1 (memory enable) and 2 (bus master) writable. Every byte from 0x40 to 0xFF is fully writable. All other header bytes outside the base registers are read-only, including 0x05, 0x0D, 0x3D, 0x3E and 0x3F.
- R5: Base register n (bytes 0x10+4n..0x13+4n, n = 0..5) has the write mask NOT(size-1), so a register of size 0 is read-only. The expansion ROM register (0x30-0x33) has the mask NOT(size-1) OR 1 when its size is nonzero.
- R6: The read length code is 0 for 1 byte, 1 for 2 bytes and 2 or 3 for 4 bytes. A 4-byte read is served only at offsets up to 0xFC, and a 2-byte read only up to 0xFE. Beyond those limits the read drops to the next smaller width that fits. Unread upper data bytes are zero.
- R7: map_update_o is high for the one cycle after a write that changes any of bytes 0x10-0x27, or that toggles bit 0 or bit 1 of byte 0x04. Otherwise it stays low.
- R8: An accepted image replaces all 256 bytes, including writable bytes and bytes that are neither writable nor constant, such as 0x05.
- R9: The constant set covers bytes 0x00-0x03, 0x08-0x0B, 0x0E, 0x34, 0x10-0x27 and 0x30-0x33, plus bit 4 of byte 0x06. An image that differs from the current contents in any constant bit that is not writable is rejected. The array is then left unchanged, and ld_err_o is high for the following cycle.
- R10: When an image is presented in a cycle, a write in that same cycle is ignored, whether the image is accepted or rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write byte offset |
| wr_len_i | input | 2 | Write length code (0:1, 1:2, 2/3:4 bytes) |
| wr_data_i | input | 32 | Write data, little-endian |
| rd_addr_i | input | 8 | Read byte offset |
| rd_len_i | input | 2 | Read length code |
| rd_data_o | output | 32 | Combinational read data |
| ld_valid_i | input | 1 | Image load strobe |
| ld_image_i | input | 2048 | Image, byte k in bits 8k+7:8k |
| ld_err_o | output | 1 | Image rejected (one-cycle pulse) |
| map_update_o | output | 1 | Address decode must be refreshed |

## Verification
The bench builds the block with base register 0 as a 16-byte I/O window and base register 1 as a 4 KiB memory window. Registers 2 to 5 are left at size zero, and the ROM is 2 KiB. This one setup covers a read-only type bit below a writable address field, whole base registers that stay read-only, and the ROM enable bit that stands apart from its address mask. With the vendor and device IDs known, the bench can build images that disturb a single constant bit, a writable address bit or a free header byte, and it sees each outcome through reads.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int SPACE_BYTES = 256;
  localparam int IMG_W       = SPACE_BYTES * 8;
  localparam int NUM_BARS    = 6;
  localparam int BAR_BYTES   = NUM_BARS * 4;

  localparam logic [7:0] OFS_CMD      = 8'h04;
  localparam logic [7:0] OFS_STATUS   = 8'h06;
  localparam logic [7:0] OFS_REV      = 8'h08;
  localparam logic [7:0] OFS_CLS_LINE = 8'h0C;
  localparam logic [7:0] OFS_HDR      = 8'h0E;
  localparam logic [7:0] OFS_BAR0     = 8'h10;
  localparam logic [7:0] OFS_ROM      = 8'h30;
  localparam logic [7:0] OFS_CAP_PTR  = 8'h34;
  localparam logic [7:0] OFS_INT_LINE = 8'h3C;
  localparam int         OFS_DEV_AREA = 'h40;

  localparam logic [7:0] CMD_IO      = 8'h01;
  localparam logic [7:0] CMD_MEM     = 8'h02;
  localparam logic [7:0] CMD_MASTER  = 8'h04;
  localparam logic [7:0] STATUS_CAPS = 8'h10;

  typedef enum logic [1:0] {LEN_1 = 2'd0, LEN_2 = 2'd1, LEN_4 = 2'd2} xfer_len_e;

  typedef logic [SPACE_BYTES-1:0][7:0] cfg_image_t;

  function automatic logic [31:0] bar_wmask(input logic [31:0] size);
    return ~(size - 32'd1);
  endfunction

  function automatic int len_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/cfg_mask_gen.sv
module cfg_mask_gen import cfg_space_pkg::*; #(
  parameter logic [15:0]                 VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0]                 DEVICE_ID   = 16'hBEEF,
  parameter logic [7:0]                  REVISION    = 8'h05,
  parameter logic [23:0]                 CLASS_CODE  = 24'h123456,
  parameter logic [7:0]                  HEADER_KIND = 8'h80,
  parameter logic [NUM_BARS-1:0][31:0]   BAR_SIZE    = {32'h0, 32'h0, 32'h0, 32'h0, 32'h1000, 32'h10},
  parameter logic [NUM_BARS-1:0]         BAR_IS_IO   = 6'b000001,
  parameter logic [31:0]                 ROM_SIZE    = 32'h800
) (
  output cfg_image_t wmask_o,
  output cfg_image_t cmask_o,
  output cfg_image_t rstval_o
);
  logic [NUM_BARS-1:0][31:0] bar_wm;
  logic [31:0]               rom_wm;

  genvar g;
  generate
    for (g = 0; g < NUM_BARS; g++) begin : g_bar
      assign bar_wm[g] = bar_wmask(BAR_SIZE[g]);
    end
  endgenerate

  // ROM keeps its enable bit writable on top of the address mask
  assign rom_wm = (ROM_SIZE == 32'd0) ? 32'd0 : (bar_wmask(ROM_SIZE) | 32'd1);

  always_comb begin
    wmask_o  = '0;
    cmask_o  = '0;
    rstval_o = '0;
    for (int b = OFS_DEV_AREA; b < SPACE_BYTES; b++) wmask_o[8'(b)] = 8'hFF;
    wmask_o[OFS_CMD]      = CMD_IO | CMD_MEM | CMD_MASTER;
    wmask_o[OFS_CLS_LINE] = 8'hFF;
    wmask_o[OFS_INT_LINE] = 8'hFF;

    for (int k = 0; k < 4; k++) begin
      cmask_o[8'(k)]              = 8'hFF;
      cmask_o[OFS_REV + 8'(k)]    = 8'hFF;
      wmask_o[OFS_ROM + 8'(k)]    = rom_wm[8*k +: 8];
      cmask_o[OFS_ROM + 8'(k)]    = 8'hFF;
    end
    cmask_o[OFS_STATUS]  = STATUS_CAPS;
    cmask_o[OFS_HDR]     = 8'hFF;
    cmask_o[OFS_CAP_PTR] = 8'hFF;

    for (int n = 0; n < NUM_BARS; n++) begin
      for (int k = 0; k < 4; k++) begin
        wmask_o[OFS_BAR0 + 8'(4*n + k)] = bar_wm[n][8*k +: 8];
        cmask_o[OFS_BAR0 + 8'(4*n + k)] = 8'hFF;
      end
      rstval_o[OFS_BAR0 + 8'(4*n)] = {7'd0, BAR_IS_IO[n]};
    end

    rstval_o[8'h00]          = VENDOR_ID[7:0];
    rstval_o[8'h01]          = VENDOR_ID[15:8];
    rstval_o[8'h02]          = DEVICE_ID[7:0];
    rstval_o[8'h03]          = DEVICE_ID[15:8];
    rstval_o[OFS_REV]        = REVISION;
    rstval_o[OFS_REV + 8'd1] = CLASS_CODE[7:0];
    rstval_o[OFS_REV + 8'd2] = CLASS_CODE[15:8];
    rstval_o[OFS_REV + 8'd3] = CLASS_CODE[23:16];
    rstval_o[OFS_HDR]        = HEADER_KIND;
  end
endmodule

// File: rtl/cfg_write_merge.sv
module cfg_write_merge import cfg_space_pkg::*; (
  input  cfg_image_t  cur_i,
  input  cfg_image_t  wmask_i,
  input  logic [7:0]  addr_i,
  input  logic [1:0]  len_i,
  input  logic [31:0] data_i,
  output cfg_image_t  nxt_o,
  output logic        remap_o
);
  logic [8:0] ofs;

  always_comb begin
    nxt_o = cur_i;
    ofs   = '0;
    for (int i = 0; i < 4; i++) begin
      ofs = {1'b0, addr_i} + 9'(i);
      // bytes beyond the top are dropped, no wrap
      if ((i < len_bytes(len_i)) && !ofs[8])
        nxt_o[ofs[7:0]] = (cur_i[ofs[7:0]] & ~wmask_i[ofs[7:0]])
                        | (data_i[8*i +: 8] & wmask_i[ofs[7:0]]);
    end
  end

  always_comb begin
    remap_o = ((cur_i[OFS_CMD] ^ nxt_o[OFS_CMD]) & (CMD_IO | CMD_MEM)) != 8'd0;
    for (int k = 0; k < BAR_BYTES; k++)
      if (nxt_o[OFS_BAR0 + 8'(k)] != cur_i[OFS_BAR0 + 8'(k)]) remap_o = 1'b1;
  end
endmodule

// File: rtl/cfg_load_check.sv
module cfg_load_check import cfg_space_pkg::*; (
  input  cfg_image_t cur_i,
  input  cfg_image_t img_i,
  input  cfg_image_t wmask_i,
  input  cfg_image_t cmask_i,
  output logic       reject_o
);
  assign reject_o = |((img_i ^ cur_i) & cmask_i & ~wmask_i);
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port import cfg_space_pkg::*; (
  input  cfg_image_t  cur_i,
  input  logic [7:0]  addr_i,
  input  logic [1:0]  len_i,
  output logic [31:0] data_o
);
  int nb;

  always_comb begin
    nb = 1;
    if (len_i == LEN_2) begin
      if (addr_i <= 8'hFE) nb = 2;
    end else if (len_i != LEN_1) begin
      if (addr_i <= 8'hFC)      nb = 4;
      else if (addr_i <= 8'hFE) nb = 2;
    end
    data_o = '0;
    for (int k = 0; k < 4; k++)
      if (k < nb) data_o[8*k +: 8] = cur_i[addr_i + 8'(k)];
  end
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs import cfg_space_pkg::*; #(
  parameter logic [15:0]               VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0]               DEVICE_ID   = 16'hBEEF,
  parameter logic [7:0]                REVISION    = 8'h05,
  parameter logic [23:0]               CLASS_CODE  = 24'h123456,
  parameter logic [7:0]                HEADER_KIND = 8'h80,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE    = {32'h0, 32'h0, 32'h0, 32'h0, 32'h1000, 32'h10},
  parameter logic [NUM_BARS-1:0]       BAR_IS_IO   = 6'b000001,
  parameter logic [31:0]               ROM_SIZE    = 32'h800
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [1:0]       wr_len_i,
  input  logic [31:0]      wr_data_i,
  input  logic [7:0]       rd_addr_i,
  input  logic [1:0]       rd_len_i,
  output logic [31:0]      rd_data_o,
  input  logic             ld_valid_i,
  input  logic [IMG_W-1:0] ld_image_i,
  output logic             ld_err_o,
  output logic             map_update_o
);
  cfg_image_t mem, mem_wr, wmask, cmask, rstval, ld_img;
  logic       remap, reject;

  assign ld_img = ld_image_i;

  cfg_mask_gen #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .CLASS_CODE(CLASS_CODE), .HEADER_KIND(HEADER_KIND),
    .BAR_SIZE(BAR_SIZE), .BAR_IS_IO(BAR_IS_IO), .ROM_SIZE(ROM_SIZE)
  ) u_masks (
    .wmask_o(wmask), .cmask_o(cmask), .rstval_o(rstval)
  );

  cfg_write_merge u_wr (
    .cur_i(mem), .wmask_i(wmask), .addr_i(wr_addr_i), .len_i(wr_len_i),
    .data_i(wr_data_i), .nxt_o(mem_wr), .remap_o(remap)
  );

  cfg_load_check u_chk (
    .cur_i(mem), .img_i(ld_img), .wmask_i(wmask), .cmask_i(cmask), .reject_o(reject)
  );

  cfg_read_port u_rd (
    .cur_i(mem), .addr_i(rd_addr_i), .len_i(rd_len_i), .data_o(rd_data_o)
  );

  // image load outranks a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem          <= rstval;
      ld_err_o     <= 1'b0;
      map_update_o <= 1'b0;
    end else begin
      ld_err_o     <= 1'b0;
      map_update_o <= 1'b0;
      if (ld_valid_i) begin
        if (reject) ld_err_o <= 1'b1;
        else        mem      <= ld_img;
      end else if (wr_en_i) begin
        mem          <= mem_wr;
        map_update_o <= remap;
      end
    end
  end

  assert_reject_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_err_o |-> (mem == $past(mem)));

  assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_err_o |-> $past(ld_valid_i));

  assert_map_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_update_o |-> $past(wr_en_i && !ld_valid_i));

  assert_id_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ld_valid_i) |-> $stable(mem[8'h00]));

  assert_load_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ld_valid_i && !reject) |-> (mem == $past(ld_img)));

  assert_top_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 8'hFF) |-> (rd_data_o[31:8] == 24'd0));
endmodule

// File: tb/cfg_space_regs_test.sv
module cfg_space_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [1:0]    wr_len = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [1:0]    rd_len = '0;
  logic [31:0]   rd_data;
  logic          ld_valid = 1'b0;
  logic [2047:0] ld_image = '0;
  logic          ld_err;
  logic          map_update;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_space_regs #(
    .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'hBEEF), .REVISION(8'h05),
    .CLASS_CODE(24'h123456), .HEADER_KIND(8'h80),
    .BAR_SIZE({32'h0, 32'h0, 32'h0, 32'h0, 32'h1000, 32'h10}),
    .BAR_IS_IO(6'b000001), .ROM_SIZE(32'h800)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_len_i(wr_len), .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_len_i(rd_len),
    .rd_data_o(rd_data), .ld_valid_i(ld_valid), .ld_image_i(ld_image),
    .ld_err_o(ld_err), .map_update_o(map_update)
  );

  // {we, waddr, wlen, wdata, raddr, rlen, rexp, map_exp}
  localparam logic [85:0] VEC [NVEC] = '{
    {1'b1, 8'h0C, 2'd0, 32'h000000AB, 8'h0C, 2'd0, 32'h000000AB, 1'b0}, // R2 R4
    {1'b1, 8'h04, 2'd1, 32'h0000FFFF, 8'h04, 2'd1, 32'h00000007, 1'b1}, // R4 R7
    {1'b1, 8'h04, 2'd0, 32'h00000006, 8'h04, 2'd0, 32'h00000006, 1'b1}, // R7 io toggle
    {1'b1, 8'h04, 2'd0, 32'h00000002, 8'h04, 2'd0, 32'h00000002, 1'b0}, // R7 master only
    {1'b1, 8'h00, 2'd2, 32'hFFFFFFFF, 8'h00, 2'd2, 32'hBEEFC0DE, 1'b0}, // R2 ids
    {1'b1, 8'h10, 2'd2, 32'hFFFFFFFF, 8'h10, 2'd2, 32'hFFFFFFF1, 1'b1}, // R5 io bar
    {1'b1, 8'h14, 2'd2, 32'hFFFFFFFF, 8'h14, 2'd2, 32'hFFFFF000, 1'b1}, // R5 mem bar
    {1'b1, 8'h18, 2'd2, 32'hFFFFFFFF, 8'h18, 2'd2, 32'h00000000, 1'b0}, // R5 size 0
    {1'b1, 8'h30, 2'd2, 32'hFFFFFFFF, 8'h30, 2'd2, 32'hFFFFF801, 1'b0}, // R5 rom
    {1'b1, 8'h14, 2'd2, 32'hFFFFFFFF, 8'h14, 2'd2, 32'hFFFFF000, 1'b0}, // R7 no change
    {1'b1, 8'h40, 2'd2, 32'h11223344, 8'h40, 2'd2, 32'h11223344, 1'b0}, // R3 R4
    {1'b1, 8'h3C, 2'd1, 32'h0000FFFF, 8'h3C, 2'd1, 32'h000000FF, 1'b0}, // R4
    {1'b1, 8'hFE, 2'd2, 32'hA1B2C3D4, 8'hFC, 2'd2, 32'hC3D40000, 1'b0}, // R3 stop at top
    {1'b1, 8'hFF, 2'd0, 32'h00000044, 8'hFD, 2'd2, 32'h0000D400, 1'b0}, // R6 4->2
    {1'b0, 8'h00, 2'd0, 32'h00000000, 8'hFF, 2'd3, 32'h00000044, 1'b0}, // R6 4->1
    {1'b0, 8'h00, 2'd0, 32'h00000000, 8'hFE, 2'd1, 32'h000044D4, 1'b0}, // R6 2 at FE
    {1'b0, 8'h00, 2'd0, 32'h00000000, 8'hFF, 2'd1, 32'h00000044, 1'b0}, // R6 2->1
    {1'b0, 8'h00, 2'd0, 32'h00000000, 8'h08, 2'd2, 32'h12345605, 1'b0}, // R1
    {1'b0, 8'h00, 2'd0, 32'h00000000, 8'h0C, 2'd2, 32'h008000AB, 1'b0}, // R4
    {1'b1, 8'h3E, 2'd2, 32'hAABBCCDD, 8'h40, 2'd2, 32'h1122AABB, 1'b0}, // R3 R4
    {1'b1, 8'h27, 2'd1, 32'h0000FFFF, 8'h24, 2'd2, 32'h00000000, 1'b0}  // R5 R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [1:0] l, input logic [31:0] e,
                        input string req);
    rd_addr = a;
    rd_len  = l;
    #1;
    chk(req, rd_data, e);
  endtask

  task automatic do_load(input logic [2047:0] im, input logic we, input logic [7:0] wa,
                         input logic [7:0] wd);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_image = im;
    wr_en    = we;
    wr_addr  = wa;
    wr_len   = 2'd0;
    wr_data  = {24'd0, wd};
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    wr_en    = 1'b0;
  endtask

  function automatic logic [2047:0] base_img();
    logic [2047:0] im = '0;
    im[8*'h00 +: 32] = 32'hBEEFC0DE;
    im[8*'h08 +: 32] = 32'h12345605;
    im[8*'h0E +: 8]  = 8'h80;
    im[8*'h10 +: 8]  = 8'h01;
    return im;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2047:0] img_a, img_b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    rd_chk(8'h00, 2'd2, 32'hBEEFC0DE, "R1 ids");
    rd_chk(8'h08, 2'd2, 32'h12345605, "R1 class/rev");
    rd_chk(8'h0C, 2'd2, 32'h00800000, "R1 header");
    rd_chk(8'h10, 2'd2, 32'h00000001, "R1 io bar type");
    rd_chk(8'h14, 2'd2, 32'h00000000, "R1 mem bar");
    rd_chk(8'h04, 2'd2, 32'h00000000, "R1 cmd/status");
    rd_chk(8'h80, 2'd2, 32'h00000000, "R1 dev area");
    chk("R7 reset pulse", {31'd0, map_update}, 32'd0);
    chk("R9 reset err", {31'd0, ld_err}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wr_en   = VEC[i][85];
      wr_addr = VEC[i][84:77];
      wr_len  = VEC[i][76:75];
      wr_data = VEC[i][74:43];
      rd_addr = VEC[i][42:35];
      rd_len  = VEC[i][34:33];
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      chk($sformatf("R2/R3/R5/R6 vector %0d data", i), rd_data, VEC[i][32:1]);
      chk($sformatf("R7 vector %0d pulse", i), {31'd0, map_update}, {31'd0, VEC[i][0]});
    end

    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    rd_chk(8'h40, 2'd2, 32'h00000000, "R1 re-reset");

    // R8: writable and free bytes differ, constant bits match
    img_a = base_img();
    img_a[8*'h10 +: 8] = 8'h21;
    img_a[8*'h04 +: 8] = 8'h07;
    img_a[8*'h05 +: 8] = 8'h33;
    img_a[8*'h50 +: 8] = 8'h9A;
    do_load(img_a, 1'b0, 8'h00, 8'h00);
    chk("R8 accept err", {31'd0, ld_err}, 32'd0);
    rd_chk(8'h10, 2'd2, 32'h00000021, "R8 bar addr");
    rd_chk(8'h04, 2'd1, 32'h00003307, "R8 cmd and free byte");
    rd_chk(8'h50, 2'd0, 32'h0000009A, "R8 dev byte");
    chk("R7 no pulse on load", {31'd0, map_update}, 32'd0);

    // R9: vendor byte mismatch
    img_b = img_a;
    img_b[8*'h00 +: 8] = 8'hDF;
    do_load(img_b, 1'b0, 8'h00, 8'h00);
    chk("R9 vendor reject", {31'd0, ld_err}, 32'd1);
    rd_chk(8'h00, 2'd1, 32'h0000C0DE, "R9 vendor kept");
    @(negedge clk);
    chk("R9 one-cycle err", {31'd0, ld_err}, 32'd0);

    // R9: bar type bit mismatch
    img_b = img_a;
    img_b[8*'h10 +: 8] = 8'h20;
    do_load(img_b, 1'b0, 8'h00, 8'h00);
    chk("R9 bar type reject", {31'd0, ld_err}, 32'd1);
    rd_chk(8'h10, 2'd0, 32'h00000021, "R9 bar kept");

    // R9: status capability bit mismatch
    img_b = img_a;
    img_b[8*'h06 +: 8] = 8'h10;
    img_b[8*'h50 +: 8] = 8'h77;
    do_load(img_b, 1'b0, 8'h00, 8'h00);
    chk("R9 status reject", {31'd0, ld_err}, 32'd1);
    rd_chk(8'h50, 2'd0, 32'h0000009A, "R9 array unchanged");

    // R10: accepted load beats write
    img_b = img_a;
    img_b[8*'h50 +: 8] = 8'h11;
    do_load(img_b, 1'b1, 8'h50, 8'h22);
    chk("R10 accept err", {31'd0, ld_err}, 32'd0);
    rd_chk(8'h50, 2'd0, 32'h00000011, "R10 load wins");

    // R10: rejected load still drops write
    img_b[8*'h01 +: 8] = 8'h00;
    do_load(img_b, 1'b1, 8'h50, 8'h55);
    chk("R10 reject err", {31'd0, ld_err}, 32'd1);
    rd_chk(8'h50, 2'd0, 32'h00000011, "R10 write dropped");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule